// File: doc/BRIEF.md
# Upset-Tolerant Request/Grant Sequencer

This block is a six-phase request/grant control machine whose stored state is protected against bit flips. A requester raises `req`. The machine passes through an arbitration phase and a grant phase, and then holds a busy phase until the work finishes or is aborted. An abort during the busy phase parks the machine in a hold-off phase until the request drops.

The state is stored as a 6-bit code. Any two legal codes differ in at least three bit positions. A compile-time parameter selects what happens when the stored code is not one of the six legal codes:
- Reset policy: the machine falls back to idle.
- Default policy: the machine goes to a chosen default phase.
- Correcting policy: the machine repairs a single flipped bit in place and carries on from the repaired phase.

Every output is decoded from the recovered phase, so a corrupted code never reaches the outputs directly. A fault-injection mask XORs into the code as it is stored. Through this mask the surrounding test logic can model upsets of any weight.

Top module: `ufsm_guard`

## Requirements
- R1: While `rst_n` is low the stored code is the idle code. The outputs read `phase`=0, with `grant`, `busy`, `rel_strobe`, `err_detected` and `err_corrected` all low.
- R2: Each phase has a fixed index and a fixed 6-bit code:
  - idle: index 0, code 000000
  - arbitrate: index 1, code 000111
  - grant: index 2, code 111000
  - busy: index 3, code 011011
  - drain: index 4, code 101101
  - hold-off: index 5, code 110110

  `phase` always shows an index below 6.
- R3: When the stored code is legal, the phase moves as follows on the next clock edge:
  - From idle, go to arbitrate if `req` is high, otherwise stay in idle.
  - From arbitrate, go to idle if `abort` is high, otherwise go to grant.
  - From grant, always go to busy.
  - From busy, go to hold-off if `abort` is high, else to drain if `done` is high, else stay in busy.
  - From drain, always go to idle.
  - From hold-off, stay in hold-off while `req` is high, otherwise go to idle.
- R4: The outputs are decoded from the recovered phase:
  - `grant` is high in grant and busy.
  - `busy` is high in arbitrate, grant, busy and drain.
  - `rel_strobe` is high in drain only.
- R5: `err_detected` is high in exactly those cycles in which the stored code is none of the six legal codes.
- R6: With the reset policy (MODE=0), an illegal code makes `phase` read idle in that cycle, and the idle code is stored at the next edge.
- R7: With the default policy (MODE=1), an illegal code makes `phase` read DEFAULT_PHASE (5, hold-off, by default) in that cycle, and that phase's code is stored at the next edge.
- R8: With the correcting policy (MODE=2), a code at distance one from a legal code is treated as that legal phase in that cycle. The machine then steps from it by the R3 rules, without restarting.
- R9: With the correcting policy, a code at distance two or more from every legal code reads as idle, and the idle code is stored at the next edge.
- R10: `err_corrected` is high only in the R8 case. It is never high without `err_detected`, and never high with MODE 0 or 1.
- R11: At each edge the stored code is the next phase's code XOR `upset_mask`. A zero mask leaves a legal code legal in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request from the client |
| done | input | 1 | Work finished during busy |
| abort | input | 1 | Cancel during arbitrate or busy |
| upset_mask | input | 6 | Bit flips applied to the code as it is stored |
| phase | output | 3 | Recovered phase index |
| grant | output | 1 | Grant to the client |
| busy | output | 1 | Sequence in progress |
| rel_strobe | output | 1 | One-cycle release in drain |
| err_detected | output | 1 | Stored code is not legal |
| err_corrected | output | 1 | Single-bit repair applied |

## Verification
Three copies of the block run side by side on the same inputs, one per policy. Their outcomes therefore split only on how each policy recovers.

A directed walk reaches the busy phase and then flips each of the six code bits in turn. This separates in-place repair from the two fallback targets. A double-bit flip then lands next to a different legal code, which exposes the known miscorrection case.

Long random runs mix quiet cycles, single flips and double flips across all phases. Double flips that land two bits from every legal code separate the R9 fallback from a wrong repair. Quiet stretches confirm that the error flags stay low and the R3 transitions hold.

// File: rtl/ufsm_pkg.sv
package ufsm_pkg;

    localparam int N_STATES = 6;
    localparam int CODE_W   = 6;
    localparam int PH_W     = $clog2(N_STATES);

    typedef enum logic [1:0] {
        MODE_SAFE_RESET   = 2'd0,
        MODE_SAFE_DEFAULT = 2'd1,
        MODE_CORRECT      = 2'd2
    } ufsm_mode_e;

    typedef enum logic [PH_W-1:0] {
        PH_IDLE    = 3'd0,
        PH_ARB     = 3'd1,
        PH_GRANT   = 3'd2,
        PH_BUSY    = 3'd3,
        PH_DRAIN   = 3'd4,
        PH_HOLDOFF = 3'd5
    } ufsm_phase_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } ufsm_regs_t;

    // Code table: pairwise Hamming distance is at least three.
    function automatic logic [CODE_W-1:0] state_code(input int idx);
        logic [CODE_W-1:0] c;
        case (idx)
            0:       c = 6'b000000;
            1:       c = 6'b000111;
            2:       c = 6'b111000;
            3:       c = 6'b011011;
            4:       c = 6'b101101;
            5:       c = 6'b110110;
            default: c = 6'b000000;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ufsm_code_check.sv
module ufsm_code_check
    import ufsm_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic              legal_o,
    output logic [PH_W-1:0]   legal_idx_o,
    output logic              near_o,
    output logic [PH_W-1:0]   near_idx_o
);

    logic [N_STATES-1:0] exact_hit;
    logic [N_STATES-1:0] near_hit;

    for (genvar s = 0; s < N_STATES; s++) begin : g_slot
        localparam logic [CODE_W-1:0] SLOT_CODE = state_code(s);
        logic [CODE_W-1:0] diff;
        assign diff         = code_i ^ SLOT_CODE;
        assign exact_hit[s] = (diff == '0);
        assign near_hit[s]  = ($countones(diff) <= 1);
    end

    always_comb begin
        legal_idx_o = '0;
        near_idx_o  = '0;
        for (int s = 0; s < N_STATES; s++) begin
            if (exact_hit[s]) legal_idx_o = PH_W'(s);
            if (near_hit[s])  near_idx_o  = PH_W'(s);
        end
    end

    assign legal_o = |exact_hit;
    assign near_o  = |near_hit;

endmodule

// File: rtl/ufsm_step.sv
module ufsm_step
    import ufsm_pkg::*;
(
    input  logic [PH_W-1:0] cur_i,
    input  logic            req_i,
    input  logic            done_i,
    input  logic            abort_i,
    output logic [PH_W-1:0] nxt_o
);

    ufsm_phase_e nxt_e;

    always_comb begin
        nxt_e = PH_IDLE;
        case (ufsm_phase_e'(cur_i))
            PH_IDLE:    nxt_e = req_i ? PH_ARB : PH_IDLE;
            PH_ARB:     nxt_e = abort_i ? PH_IDLE : PH_GRANT;
            PH_GRANT:   nxt_e = PH_BUSY;
            PH_BUSY: begin
                if (abort_i)     nxt_e = PH_HOLDOFF;
                else if (done_i) nxt_e = PH_DRAIN;
                else             nxt_e = PH_BUSY;
            end
            PH_DRAIN:   nxt_e = PH_IDLE;
            PH_HOLDOFF: nxt_e = req_i ? PH_HOLDOFF : PH_IDLE;
            default:    nxt_e = PH_IDLE;
        endcase
    end

    assign nxt_o = nxt_e;

endmodule

// File: rtl/ufsm_outdec.sv
module ufsm_outdec
    import ufsm_pkg::*;
(
    input  logic [PH_W-1:0] ph_i,
    output logic            grant_o,
    output logic            busy_o,
    output logic            rel_o
);

    always_comb begin
        grant_o = 1'b0;
        busy_o  = 1'b0;
        rel_o   = 1'b0;
        case (ufsm_phase_e'(ph_i))
            PH_ARB:   busy_o = 1'b1;
            PH_GRANT: begin grant_o = 1'b1; busy_o = 1'b1; end
            PH_BUSY:  begin grant_o = 1'b1; busy_o = 1'b1; end
            PH_DRAIN: begin busy_o  = 1'b1; rel_o  = 1'b1; end
            default:  ;
        endcase
    end

endmodule

// File: rtl/ufsm_guard.sv
module ufsm_guard
    import ufsm_pkg::*;
#(
    parameter ufsm_mode_e MODE          = MODE_CORRECT,
    parameter int         DEFAULT_PHASE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              done,
    input  logic              abort,
    input  logic [CODE_W-1:0] upset_mask,
    output logic [PH_W-1:0]   phase,
    output logic              grant,
    output logic              busy,
    output logic              rel_strobe,
    output logic              err_detected,
    output logic              err_corrected
);

    localparam logic [PH_W-1:0]   DFLT_IDX  = PH_W'(DEFAULT_PHASE);
    localparam logic [CODE_W-1:0] IDLE_CODE = state_code(0);

    ufsm_regs_t q, d;

    logic            legal;
    logic [PH_W-1:0] legal_idx;
    logic            near;
    logic [PH_W-1:0] near_idx;

    logic            rec_step;
    logic            rec_fix;
    logic [PH_W-1:0] rec_idx;

    logic [PH_W-1:0] eff_idx;
    logic [PH_W-1:0] step_idx;
    logic            use_step;

    ufsm_code_check u_check (
        .code_i      (q.code),
        .legal_o     (legal),
        .legal_idx_o (legal_idx),
        .near_o      (near),
        .near_idx_o  (near_idx)
    );

    // Recovery policy chosen at elaboration.
    if (MODE == MODE_CORRECT) begin : g_fix
        assign rec_step = near;
        assign rec_fix  = near;
        assign rec_idx  = near ? near_idx : PH_W'(PH_IDLE);
    end else if (MODE == MODE_SAFE_DEFAULT) begin : g_dflt
        assign rec_step = 1'b0;
        assign rec_fix  = 1'b0;
        assign rec_idx  = DFLT_IDX;
    end else begin : g_rst
        assign rec_step = 1'b0;
        assign rec_fix  = 1'b0;
        assign rec_idx  = PH_W'(PH_IDLE);
    end

    assign eff_idx  = legal ? legal_idx : rec_idx;
    assign use_step = legal | rec_step;

    ufsm_step u_step (
        .cur_i   (eff_idx),
        .req_i   (req),
        .done_i  (done),
        .abort_i (abort),
        .nxt_o   (step_idx)
    );

    ufsm_outdec u_out (
        .ph_i    (eff_idx),
        .grant_o (grant),
        .busy_o  (busy),
        .rel_o   (rel_strobe)
    );

    always_comb begin
        d      = q;
        d.code = state_code(int'(use_step ? step_idx : eff_idx)) ^ upset_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.code <= IDLE_CODE;
        else        q      <= d;
    end

    assign phase         = eff_idx;
    assign err_detected  = ~legal;
    assign err_corrected = ~legal & rec_fix;

    // ---------------- assertions ----------------
    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PH_W'(N_STATES));

    p_idle_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_W'(PH_IDLE) && !err_detected && req && upset_mask == '0)
        |=> (phase == PH_W'(PH_ARB)));

    p_grant_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> busy);

    p_heal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_detected && upset_mask == '0) |=> !err_detected);

    p_zero_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_detected && upset_mask == '0) |=> !err_detected);

    p_cor_det_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_corrected |-> err_detected);

    if (MODE == MODE_SAFE_RESET) begin : g_chk_rst
        p_safe_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (err_detected && upset_mask == '0) |=> (phase == PH_W'(PH_IDLE)));
        p_no_cor_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !err_corrected);
    end else if (MODE == MODE_SAFE_DEFAULT) begin : g_chk_dflt
        p_safe_dflt_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (err_detected && upset_mask == '0) |=> (phase == DFLT_IDX));
        p_no_cor_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !err_corrected);
    end else begin : g_chk_fix
        p_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (err_detected && !err_corrected && upset_mask == '0)
            |=> (phase == PH_W'(PH_IDLE)));
        p_fix_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (err_corrected && phase == PH_W'(PH_GRANT) && upset_mask == '0)
            |=> (phase == PH_W'(PH_BUSY)));
    end

endmodule

// File: tb/ufsm_guard_test.sv
`timescale 1ns/1ps
module ufsm_guard_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req, done, abort;
    logic [5:0] mask;

    logic [2:0] ph   [3];
    logic       gr   [3];
    logic       bz   [3];
    logic       rl   [3];
    logic       det  [3];
    logic       cor  [3];

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    string walk_tag = "";
    logic [5:0] pmask = '0;

    logic [5:0] mcode [3];

    always #4 clk = ~clk;

    // index 0: reset policy, 1: default policy, 2: correcting policy
    ufsm_guard #(.MODE(ufsm_pkg::MODE_SAFE_RESET)) uut_rst (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done), .abort(abort),
        .upset_mask(mask), .phase(ph[0]), .grant(gr[0]), .busy(bz[0]),
        .rel_strobe(rl[0]), .err_detected(det[0]), .err_corrected(cor[0]));

    ufsm_guard #(.MODE(ufsm_pkg::MODE_SAFE_DEFAULT)) uut_dft (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done), .abort(abort),
        .upset_mask(mask), .phase(ph[1]), .grant(gr[1]), .busy(bz[1]),
        .rel_strobe(rl[1]), .err_detected(det[1]), .err_corrected(cor[1]));

    ufsm_guard #(.MODE(ufsm_pkg::MODE_CORRECT)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done), .abort(abort),
        .upset_mask(mask), .phase(ph[2]), .grant(gr[2]), .busy(bz[2]),
        .rel_strobe(rl[2]), .err_detected(det[2]), .err_corrected(cor[2]));

    function automatic logic [5:0] bcode(int i);
        case (i)
            1: return 6'b000111;
            2: return 6'b111000;
            3: return 6'b011011;
            4: return 6'b101101;
            5: return 6'b110110;
            default: return 6'b000000;
        endcase
    endfunction

    function automatic int bstep(int p, bit rq, bit dn, bit ab);
        case (p)
            0: return rq ? 1 : 0;
            1: return ab ? 0 : 2;
            2: return 3;
            3: return ab ? 5 : (dn ? 4 : 3);
            4: return 0;
            5: return rq ? 5 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic void beval(int m, logic [5:0] c, bit rq, bit dn, bit ab,
                                  output int eff, output int nxt,
                                  output bit e_det, output bit e_cor);
        int hit = -1;
        int nearest = -1;
        e_det = 0; e_cor = 0;
        for (int i = 0; i < 6; i++) begin
            if (c == bcode(i)) hit = i;
            if ($countones(c ^ bcode(i)) <= 1) nearest = i;
        end
        if (hit >= 0) begin
            eff = hit; nxt = bstep(hit, rq, dn, ab);
        end else begin
            e_det = 1;
            if (m == 0) begin eff = 0; nxt = 0; end
            else if (m == 1) begin eff = 5; nxt = 5; end
            else if (nearest >= 0) begin
                eff = nearest; nxt = bstep(nearest, rq, dn, ab); e_cor = 1;
            end else begin eff = 0; nxt = 0; end
        end
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic verify();
        for (int m = 0; m < 3; m++) begin
            int eff, nxt;
            bit e_det, e_cor;
            string ptag;
            beval(m, mcode[m], req, done, abort, eff, nxt, e_det, e_cor);
            if (e_det) ptag = (m == 0) ? "R6" : (m == 1) ? "R7" : (e_cor ? "R8" : "R9");
            else if (walk_tag != "") ptag = walk_tag;
            else ptag = "R3";
            chk(ptag, $sformatf("phase[%0d]", m), int'(ph[m]), eff);
            chk("R4", $sformatf("grant[%0d]", m), int'(gr[m]), int'(eff == 2 || eff == 3));
            chk("R4", $sformatf("busy[%0d]", m), int'(bz[m]), int'(eff >= 1 && eff <= 4));
            chk("R4", $sformatf("rel[%0d]", m), int'(rl[m]), int'(eff == 4));
            chk((pmask == '0) ? "R11" : "R5", $sformatf("det[%0d]", m), int'(det[m]), int'(e_det));
            chk("R10", $sformatf("cor[%0d]", m), int'(cor[m]), int'(e_cor));
        end
    endtask

    // one clock: drive at negedge, check, then advance models at the edge
    task automatic run(bit rq, bit dn, bit ab, logic [5:0] mk);
        req = rq; done = dn; abort = ab; mask = mk;
        #1;
        verify();
        @(posedge clk);
        for (int m = 0; m < 3; m++) begin
            int eff, nxt;
            bit e_det, e_cor;
            beval(m, mcode[m], rq, dn, ab, eff, nxt, e_det, e_cor);
            mcode[m] = bcode(nxt) ^ mk;
        end
        pmask = mk;
        @(negedge clk);
    endtask

    task automatic walk_to_busy();
        run(1, 0, 0, '0);
        run(0, 0, 0, '0);
        run(0, 0, 0, '0);
    endtask

    initial begin
        void'($urandom(32'd5171));
        rst_n = 1'b0; req = 0; done = 0; abort = 0; mask = '0;
        for (int m = 0; m < 3; m++) mcode[m] = 6'b000000;
        repeat (3) @(negedge clk);
        // R1: reset state on every policy
        for (int m = 0; m < 3; m++) begin
            chk("R1", $sformatf("reset phase[%0d]", m), int'(ph[m]), 0);
            chk("R1", $sformatf("reset outs[%0d]", m),
                int'({gr[m], bz[m], rl[m], det[m], cor[m]}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: directed walk through the phase indices
        walk_tag = "R2";
        walk_to_busy();
        run(0, 1, 0, '0);
        run(0, 0, 0, '0);
        walk_to_busy();
        run(1, 0, 1, '0);
        run(1, 0, 0, '0);
        run(0, 0, 0, '0);
        walk_tag = "";

        // single-bit flips from busy, one per code bit
        for (int b = 0; b < 6; b++) begin
            run(0, 0, 0, '0);
            walk_to_busy();
            run(0, 0, 0, 6'(1) << b);
            run(0, 0, 0, '0);
            run(0, 0, 0, '0);
            run(0, 1, 0, '0);
            run(0, 0, 0, '0);
            run(0, 0, 0, '0);
        end

        // double-bit flip next to another legal code, and one far from all
        walk_to_busy();
        run(0, 0, 0, 6'b000011);
        run(0, 0, 0, '0);
        run(0, 0, 1, '0);
        run(0, 0, 0, '0);
        run(0, 0, 0, 6'b100001);
        run(0, 0, 0, '0);

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [5:0] mk;
            r = $urandom_range(99);
            mk = '0;
            if (r >= 84 && r < 95) mk = 6'(1) << $urandom_range(5);
            else if (r >= 95) begin
                int a, b2;
                a = $urandom_range(5);
                b2 = (a + 1 + $urandom_range(4)) % 6;
                mk = (6'(1) << a) | (6'(1) << b2);
            end
            run($urandom_range(99) < 55, $urandom_range(99) < 30,
                $urandom_range(99) < 12, mk);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule